// File: doc/BRIEF.md
# Triggered UART Transmit Launcher

This block sits beside a UART transmitter and starts a transmit burst when a hardware trigger fires, with no processor action needed. Software programs one control word: how many data words to send, which of sixteen trigger lines to watch, which edge of that line counts, whether triggering is armed, and whether the idle frame that normally follows transmitter enable is skipped.

When the chosen edge arrives on the chosen line while the unit is enabled and triggering is armed, the block raises the transmitter enable, optionally asks for one idle frame, then asks for the programmed number of data words through a request/acknowledge handshake. After the last acknowledge it pulses a done flag and waits for the next trigger. The control word is frozen while the unit is enabled, and dropping the unit enable aborts everything. Serial bit timing lives in the transmitter and is not part of this block.

Top module: `tx_trig_launcher`

## Requirements
- R1: After reset the control word reads 0 and tx_en_o, tx_req_o, tx_idle_o and done_o are all 0.
- R2: The control word holds the count in bits [15:0], polarity in bit 16, trigger enable in bit 17, idle disable in bit 19 and trigger select in bits [23:20]; every other bit reads 0 (writing all ones reads back 0x00FB_FFFF).
- R3: A write made while unit_en_i is 1 leaves the control word unchanged.
- R4: Select value N makes trig_i[N] the only line that can launch a burst; edges on other lines have no effect.
- R5: Polarity 0 launches on a 0-to-1 change of the selected line, polarity 1 on a 1-to-0 change; the opposite edge launches nothing. The launch shows on the outputs within four clock edges of the line change.
- R6: With trigger enable 0, edges on the selected line launch nothing: no request, no done pulse, tx_en_o stays 0.
- R7: A launch sets tx_en_o to 1, and it stays 1 after the burst until unit_en_i is cleared.
- R8: With idle disable 0, the first request after a launch has tx_idle_o=1 and exactly one such request is made; with idle disable 1 no request has tx_idle_o=1.
- R9: Exactly count data requests (tx_idle_o=0) are acknowledged per launch, after which done_o is 1 for exactly one cycle; a count of 0 yields no data request but still a done pulse and tx_en_o=1.
- R10: A trigger edge that arrives while a burst is in progress is ignored: the burst still sends count words and produces one done pulse.
- R11: Clearing unit_en_i clears tx_en_o and tx_req_o on the next clock edge and the block returns to waiting for a trigger.
- R12: One trigger edge produces one launch; holding the line at its active level starts no further burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_en_i | input | 1 | Unit enable; locks the control word, 0 aborts |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| trig_i | input | 16 | Trigger lines |
| tx_ack_i | input | 1 | Transmitter accepts the current request |
| tx_en_o | output | 1 | Transmitter enable |
| tx_req_o | output | 1 | Request for one frame |
| tx_idle_o | output | 1 | Current request is an idle frame (1) or data word (0) |
| done_o | output | 1 | One-cycle pulse at burst end |

## Verification
The assertions take for granted that the transmitter raises tx_ack_i only while tx_req_o is 1 and that the select and polarity fields settle, with the trigger lines at their inactive level, for a few cycles before the unit is enabled, so no stale edge sits in the synchronizer. The stimulus keeps to this by acknowledging only on cycles where a request was seen, holding each acknowledge for a single cycle, and always parking every trigger line at the inactive level of the programmed polarity before writing the control word and waiting before raising unit_en_i.

// File: rtl/txl_pkg.sv
package txl_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned N_TRIG   = 1 << SEL_W;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned POS_POL  = CNT_W;
  localparam int unsigned POS_TEN  = CNT_W + 1;
  localparam int unsigned POS_IDIS = CNT_W + 3;
  localparam int unsigned POS_SEL  = CNT_W + 4;
  localparam int unsigned SYNC_N   = 2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             idle_dis;
    logic             trig_en;
    logic             pol;
    logic [CNT_W-1:0] cnt;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_DATA = 2'd2
  } st_e;
endpackage

// File: rtl/txl_cfg_reg.sv
module txl_cfg_reg
  import txl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unit_en_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output cfg_t             cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d.cnt      = wdata_i[CNT_W-1:0];
    cfg_d.pol      = wdata_i[POS_POL];
    cfg_d.trig_en  = wdata_i[POS_TEN];
    cfg_d.idle_dis = wdata_i[POS_IDIS];
    cfg_d.sel      = wdata_i[POS_SEL +: SEL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= '0;
    else if (we_i && !unit_en_i) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[CNT_W-1:0]       = cfg_q.cnt;
    rdata_o[POS_POL]         = cfg_q.pol;
    rdata_o[POS_TEN]         = cfg_q.trig_en;
    rdata_o[POS_IDIS]        = cfg_q.idle_dis;
    rdata_o[POS_SEL +: SEL_W] = cfg_q.sel;
  end

  assign cfg_o = cfg_q;

  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_en_i |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/txl_trig_detect.sv
module txl_trig_detect
  import txl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pol_i,
  output logic              edge_o
);
  // normalise so the active edge is always a rise
  logic              lvl;
  logic [SYNC_N:0]   sh_q;

  assign lvl = trig_i[sel_i] ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q[0] <= 1'b0;
    else         sh_q[0] <= lvl;
  end

  for (genvar g = 1; g <= SYNC_N; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[g] <= 1'b0;
      else         sh_q[g] <= sh_q[g-1];
    end
  end

  assign edge_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R12
endmodule

// File: rtl/txl_burst_fsm.sv
module txl_burst_fsm
  import txl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unit_en_i,
  input  logic             edge_i,
  input  logic             trig_en_i,
  input  logic             idle_dis_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tx_ack_i,
  output logic             tx_en_o,
  output logic             tx_req_o,
  output logic             tx_idle_o,
  output logic             done_o
);
  st_e              st_q;
  logic [CNT_W-1:0] rem_q;
  logic             en_q, done_q, launch;

  assign launch = edge_i & trig_en_i & unit_en_i & (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      rem_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (!unit_en_i) begin
      st_q   <= ST_WAIT;
      rem_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_WAIT: if (launch) begin
          en_q  <= 1'b1;
          rem_q <= cnt_i;
          if (!idle_dis_i)      st_q <= ST_IDLE;
          else if (cnt_i == '0) done_q <= 1'b1;
          else                  st_q <= ST_DATA;
        end
        ST_IDLE: if (tx_ack_i) begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            st_q   <= ST_WAIT;
          end else begin
            st_q   <= ST_DATA;
          end
        end
        ST_DATA: if (tx_ack_i) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            done_q <= 1'b1;
            st_q   <= ST_WAIT;
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

  assign tx_en_o   = en_q;
  assign tx_req_o  = (st_q != ST_WAIT);
  assign tx_idle_o = (st_q == ST_IDLE);
  assign done_o    = done_q;

  AST_ACK_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_i |-> tx_req_o); // R9
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unit_en_i |=> (!tx_en_o && !tx_req_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> tx_en_o); // R7
  AST_NO_TRIG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !trig_en_i) |=> (st_q == ST_WAIT && !done_o)); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !tx_ack_i && unit_en_i) |=> st_q == ST_DATA); // R10
  AST_REM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> (rem_q != '0)); // R9
  AST_IDLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_idle_o && !$past(tx_idle_o)) |-> !$past(tx_req_o)); // R8
endmodule

// File: rtl/tx_trig_launcher.sv
module tx_trig_launcher
  import txl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              unit_en_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              tx_ack_i,
  output logic              tx_en_o,
  output logic              tx_req_o,
  output logic              tx_idle_o,
  output logic              done_o
);
  cfg_t cfg;
  logic trig_edge;

  txl_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unit_en_i (unit_en_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .cfg_o     (cfg),
    .rdata_o   (reg_rdata_o)
  );

  txl_trig_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .sel_i  (cfg.sel),
    .pol_i  (cfg.pol),
    .edge_o (trig_edge)
  );

  txl_burst_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .unit_en_i  (unit_en_i),
    .edge_i     (trig_edge),
    .trig_en_i  (cfg.trig_en),
    .idle_dis_i (cfg.idle_dis),
    .cnt_i      (cfg.cnt),
    .tx_ack_i   (tx_ack_i),
    .tx_en_o    (tx_en_o),
    .tx_req_o   (tx_req_o),
    .tx_idle_o  (tx_idle_o),
    .done_o     (done_o)
  );

  AST_IDLE_IMPLIES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> tx_req_o); // R8
endmodule

// File: tb/tx_trig_launcher_bench.sv
module tx_trig_launcher_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        unit_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] trig_i = '0;
  logic        tx_ack_i = 1'b0;
  logic        tx_en_o, tx_req_o, tx_idle_o, done_o;

  int n_total = 0;
  int n_bad   = 0;

  tx_trig_launcher u_tx_trig_launcher (.*);

  always #5 clk_i = ~clk_i;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int cnt, input bit pol, input bit ten,
                                       input bit idis, input int sel);
    return 32'(cnt & 16'hFFFF) | (32'(pol) << 16) | (32'(ten) << 17) |
           (32'(idis) << 19) | (32'(sel & 15) << 20);
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic setup(input int cnt, input bit pol, input bit ten, input bit idis,
                       input int sel);
    @(negedge clk_i);
    unit_en_i = 1'b0;
    tx_ack_i  = 1'b0;
    trig_i    = pol ? 16'hFFFF : 16'h0000;
    wr(word(cnt, pol, ten, idis, sel));
    repeat (4) @(negedge clk_i);
    unit_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  // transmitter model: acknowledge each request for one cycle until done
  task automatic serve(output int n_idle, output int n_data, output int n_done,
                       output int n_extra, output bit order_ok);
    bit seen_data = 1'b0;
    n_idle = 0; n_data = 0; n_done = 0; n_extra = 0; order_ok = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk_i);
      if (done_o) begin
        n_done++;
        tx_ack_i = 1'b0;
        break;
      end
      if (tx_ack_i) tx_ack_i = 1'b0;
      else if (tx_req_o) begin
        if (tx_idle_o) begin
          n_idle++;
          if (seen_data) order_ok = 1'b0;
        end else begin
          n_data++;
          seen_data = 1'b1;
        end
        tx_ack_i = 1'b1;
      end
    end
    tx_ack_i = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk_i);
      if (done_o)   n_done++;
      if (tx_req_o) n_extra++;
    end
  endtask

  task automatic quiet(input int cycles, output int hits);
    hits = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (tx_req_o || done_o || tx_en_o) hits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int ni, nd, ndn, nx, hits, run;
    bit ok;
    repeat (3) @(negedge clk_i);
    chk(reg_rdata_o == 0, "R1 rdata", int'(reg_rdata_o), 0);
    chk({tx_en_o, tx_req_o, tx_idle_o, done_o} == 4'b0, "R1 outputs",
        int'({tx_en_o, tx_req_o, tx_idle_o, done_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(reg_rdata_o == 0, "R1 rdata after release", int'(reg_rdata_o), 0);

    // R2 field layout and reserved bits
    wr(32'hFFFF_FFFF);
    chk(reg_rdata_o == 32'h00FB_FFFF, "R2 all ones", int'(reg_rdata_o), 32'h00FB_FFFF);
    wr(word(16'h1234, 1'b0, 1'b1, 1'b0, 9));
    chk(reg_rdata_o == 32'h0092_1234, "R2 pattern", int'(reg_rdata_o), 32'h0092_1234);

    // R3 writes locked while enabled
    @(negedge clk_i); unit_en_i = 1'b1;
    wr(32'h0000_0000);
    chk(reg_rdata_o == 32'h0092_1234, "R3 locked", int'(reg_rdata_o), 32'h0092_1234);
    @(negedge clk_i); unit_en_i = 1'b0;
    wr(32'h0000_0000);
    chk(reg_rdata_o == 0, "R3 unlocked write", int'(reg_rdata_o), 0);

    // main sweep: count x idle_dis x polarity, select rotating
    run = 0;
    for (int cnt = 0; cnt < 5; cnt++)
      for (int idis = 0; idis < 2; idis++)
        for (int pol = 0; pol < 2; pol++) begin
          int sel = (run * 7 + 3) % 16;
          run++;
          setup(cnt, pol[0], 1'b1, idis[0], sel);
          chk(!tx_en_o, "R7 en before trigger", int'(tx_en_o), 0);
          @(negedge clk_i); trig_i[sel] = ~trig_i[sel];
          serve(ni, nd, ndn, nx, ok);
          chk(ni == (idis ? 0 : 1), "R8 idle count", ni, idis ? 0 : 1);
          chk(ok, "R8 idle first", int'(ok), 1);
          chk(nd == cnt, pol ? "R9 data count (R5 falling)" : "R9 data count (R5 rising)",
              nd, cnt);
          chk(ndn == 1, "R9 one done pulse", ndn, 1);
          chk(nx == 0, "R12 no relaunch while held", nx, 0);
          chk(tx_en_o, "R7 en stays set", int'(tx_en_o), 1);
        end

    // R5 opposite edge ignored
    @(negedge clk_i); unit_en_i = 1'b0; trig_i = 16'hFFFF;
    wr(word(2, 1'b0, 1'b1, 1'b1, 4));
    repeat (4) @(negedge clk_i); unit_en_i = 1'b1;
    repeat (2) @(negedge clk_i); trig_i[4] = 1'b0;
    quiet(8, hits);
    chk(hits == 0, "R5 opposite edge", hits, 0);

    // R6 trigger disabled
    setup(3, 1'b0, 1'b0, 1'b1, 6);
    @(negedge clk_i); trig_i[6] = 1'b1;
    quiet(8, hits);
    chk(hits == 0, "R6 disabled trigger", hits, 0);

    // R4 unselected line ignored, selected line launches
    setup(2, 1'b0, 1'b1, 1'b1, 5);
    @(negedge clk_i); trig_i = 16'hFFDF;
    quiet(8, hits);
    chk(hits == 0, "R4 other lines", hits, 0);
    @(negedge clk_i); trig_i[5] = 1'b1;
    serve(ni, nd, ndn, nx, ok);
    chk(nd == 2 && ndn == 1, "R4 selected line", nd, 2);

    // R10 trigger during burst ignored
    setup(10, 1'b0, 1'b1, 1'b1, 12);
    @(negedge clk_i); trig_i[12] = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(tx_req_o, "R10 burst started", int'(tx_req_o), 1);
    trig_i[12] = 1'b0;
    repeat (4) @(negedge clk_i);
    trig_i[12] = 1'b1;
    repeat (5) @(negedge clk_i);
    serve(ni, nd, ndn, nx, ok);
    chk(nd == 10, "R10 data count", nd, 10);
    chk(ndn == 1 && nx == 0, "R10 single done", ndn, 1);

    // R11 abort
    setup(10, 1'b0, 1'b1, 1'b1, 0);
    @(negedge clk_i); trig_i[0] = 1'b1;
    nd = 0;
    while (nd < 2) begin
      @(negedge clk_i);
      if (tx_ack_i) tx_ack_i = 1'b0;
      else if (tx_req_o) begin tx_ack_i = 1'b1; nd++; end
    end
    @(negedge clk_i); tx_ack_i = 1'b0; unit_en_i = 1'b0;
    @(negedge clk_i);
    chk(!tx_en_o && !tx_req_o, "R11 abort", int'({tx_en_o, tx_req_o}), 0);
    unit_en_i = 1'b1;
    quiet(6, hits);
    chk(hits == 0, "R11 back to waiting", hits, 0);

    summary();
    $finish;
  end
endmodule